// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Model

This block models a memory with independent read and write ports. Every access moves two data beats. Beat 0 carries the even word of an addressed word pair and beat 1 carries the odd word. The two beats run at twice the rate of the master clock.

The design runs on a single double-rate clock `clk2x`. An internal phase bit marks every second edge of `clk2x` as a master rising edge, and the bit is visible on `master_ph`. Commands, addresses and write data are sampled only on master edges.

- **Read timing.** A read command and its address are taken on one master edge. Both read beats come out in the two half-cycles that follow the next master edge.
- **Write timing.** A write command and its first data beat are taken on one master edge. The write address and the second data beat are taken on the following master edge, and the pair is committed on that edge.

Reads and writes may be issued in every master cycle, both in the same cycle. When a read collides with a write whose address is still in flight, the read is served through a bypass.

The read output is a stream marked by `rd_valid` and has no ready signal. The consumer cannot apply back-pressure and must take each beat in the half-cycle in which it is shown.

Top module: `burst2_sram`

## Requirements
- R1: On a master edge, a low `rd_req_n` starts a read of the pair at `rd_addr`. A high `rd_req_n` is a deselect, and that read slot later shows `rd_valid` low.
- R2: The read beats appear in the half-cycle after the next master edge (even word, 2*A) and in the half-cycle after that (odd word, 2*A+1), where A is the sampled pair address.
- R3: `rd_valid` is high only during the two beats of a read. Whenever `rd_valid` is low, `rd_data` is zero.
- R4: On a master edge, a low `wr_req_n` starts a write and `wr_data` is taken as its first beat. On the next master edge, `wr_addr` and `wr_data` (the second beat) are taken, and the beats are stored in words 2*A and 2*A+1.
- R5: A high `wr_req_n` on a master edge is a write deselect and leaves the array unchanged.
- R6: A read and a write can both be issued on every master edge without affecting each other, so alternating or simultaneous traffic runs at full rate.
- R7: A read issued on the same master edge as a write command, to the pair that the write names on the next edge, returns the newly written beats.
- R8: A synchronous active-high `rst` cancels any pending read and any pending write, holds `rd_valid` low and `rd_data` zero, and returns the phase to the master half. The array contents survive reset.
- R9: `master_ph` is 0 in every half-cycle whose closing `clk2x` edge is a master edge, and it alternates on every edge out of reset.
- R10: The values of all command, address and data inputs at non-master edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; every second rising edge is a master edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_n | input | 1 | Read command, active low |
| rd_addr | input | AW | Read pair address |
| rd_valid | output | 1 | High during the two read beats |
| rd_data | output | DW | Read beat; zero when not valid |
| wr_req_n | input | 1 | Write command, active low |
| wr_addr | input | AW | Write pair address, taken one master edge after the command |
| wr_data | input | DW | Write beat, sampled on master edges |
| master_ph | output | 1 | 0 when the next edge is a master edge |

## Verification
The read output stage and the commit of a pending write can land on the same master edge. In that case the read's even and odd words are being written at that instant. The bench provokes this by issuing a read and a write command together and naming the same pair on the next write address, in a directed case and throughout the sweeps. The read beats are compared with the values the write delivered, computed by the bench's pair model, which commits the write before it looks up the read. The sweeps also vary the read and write addresses and the enable patterns, so that the bypass and non-bypass paths both occur in adjacent cycles.

// File: rtl/b2_pkg.sv
`timescale 1ns/1ps
package b2_pkg;
  // Half-cycle marker of the double-rate clock
  typedef enum logic {
    PH_MASTER = 1'b0,  // closing edge is a master rising edge
    PH_MID    = 1'b1   // closing edge is the mid-cycle edge
  } half_e;
endpackage

// File: rtl/b2_phase.sv
`timescale 1ns/1ps
module b2_phase
  import b2_pkg::*;
(
  input  logic  clk2x,
  input  logic  rst,
  output half_e ph
);
  always_ff @(posedge clk2x) begin
    if (rst) ph <= PH_MASTER;
    else     ph <= (ph == PH_MASTER) ? PH_MID : PH_MASTER;
  end
endmodule

// File: rtl/b2_wr_pipe.sv
`timescale 1ns/1ps
module b2_wr_pipe #(
  parameter int DW = 8
) (
  input  logic          clk2x,
  input  logic          rst,
  input  logic          at_master,
  input  logic          wr_req_n,
  input  logic [DW-1:0] wr_data,
  output logic          pend,
  output logic [DW-1:0] beat0,
  output logic          commit
);
  // Command plus first beat on one master edge; commit on the next one
  always_ff @(posedge clk2x) begin
    if (rst) begin
      pend  <= 1'b0;
      beat0 <= '0;
    end else if (at_master) begin
      pend <= ~wr_req_n;
      if (!wr_req_n) beat0 <= wr_data;
    end
  end

  assign commit = at_master & pend;
endmodule

// File: rtl/b2_pair_array.sv
`timescale 1ns/1ps
module b2_pair_array #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic            clk2x,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [2*DW-1:0] wpair,
  input  logic [AW-1:0]   raddr,
  output logic [2*DW-1:0] rpair
);
  localparam int PAIRS = 1 << AW;

  // Low half of each entry is the even word, high half the odd word
  logic [2*DW-1:0] mem [PAIRS];

  always_ff @(posedge clk2x) begin
    if (we) mem[waddr] <= wpair;
  end

  assign rpair = mem[raddr];
endmodule

// File: rtl/b2_rd_pipe.sv
`timescale 1ns/1ps
module b2_rd_pipe #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk2x,
  input  logic          rst,
  input  logic          at_master,
  input  logic          rd_req_n,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] addr_q,
  input  logic [DW-1:0] word_even,
  input  logic [DW-1:0] word_odd,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          pend;
  logic [DW-1:0] hold_odd;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      pend     <= 1'b0;
      addr_q   <= '0;
      hold_odd <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (at_master) begin
      pend   <= ~rd_req_n;
      addr_q <= rd_addr;
      if (pend) begin
        rd_data  <= word_even;
        hold_odd <= word_odd;
        rd_valid <= 1'b1;
      end else begin
        rd_data  <= '0;
        rd_valid <= 1'b0;
      end
    end else if (rd_valid) begin
      rd_data <= hold_odd;  // second beat, half a master cycle later
    end
  end
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
module burst2_sram
  import b2_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk2x,
  input  logic          rst,
  input  logic          rd_req_n,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          wr_req_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          master_ph
);
  half_e           ph;
  logic            at_master;
  logic            wr_pend, wr_commit;
  logic [DW-1:0]   wr_beat0;
  logic [AW-1:0]   rd_addr_q;
  logic [2*DW-1:0] arr_pair;
  logic [DW-1:0]   beat_word [2];
  logic            bypass;

  b2_phase u_phase (.clk2x(clk2x), .rst(rst), .ph(ph));
  assign at_master = (ph == PH_MASTER);
  assign master_ph = ph;

  b2_wr_pipe #(.DW(DW)) u_wr (
    .clk2x(clk2x), .rst(rst), .at_master(at_master),
    .wr_req_n(wr_req_n), .wr_data(wr_data),
    .pend(wr_pend), .beat0(wr_beat0), .commit(wr_commit)
  );

  b2_pair_array #(.AW(AW), .DW(DW)) u_arr (
    .clk2x(clk2x), .we(wr_commit), .waddr(wr_addr),
    .wpair({wr_data, wr_beat0}), .raddr(rd_addr_q), .rpair(arr_pair)
  );

  // A write committing on this master edge to the pair being read wins
  assign bypass = wr_pend && (wr_addr == rd_addr_q);

  for (genvar b = 0; b < 2; b++) begin : g_beat
    logic [DW-1:0] fresh;
    assign fresh = (b == 0) ? wr_beat0 : wr_data;
    assign beat_word[b] = bypass ? fresh : arr_pair[b*DW +: DW];
  end

  b2_rd_pipe #(.AW(AW), .DW(DW)) u_rd (
    .clk2x(clk2x), .rst(rst), .at_master(at_master),
    .rd_req_n(rd_req_n), .rd_addr(rd_addr), .addr_q(rd_addr_q),
    .word_even(beat_word[0]), .word_odd(beat_word[1]),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/burst2_sram_chk.sv
`timescale 1ns/1ps
module burst2_sram_chk #(
  parameter int DW = 8
) (
  input logic          clk2x,
  input logic          rst,
  input logic          rd_req_n,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          master_ph
);
  assert_idle_zero_R3: assert property (@(posedge clk2x) disable iff (rst)
    !rd_valid |-> rd_data == '0);

  assert_first_beat_half_R2: assert property (@(posedge clk2x) disable iff (rst)
    $rose(rd_valid) |-> master_ph == 1'b1);

  assert_second_beat_follows_R2: assert property (@(posedge clk2x) disable iff (rst)
    (rd_valid && master_ph == 1'b1) |=> rd_valid);

  assert_read_starts_R1: assert property (@(posedge clk2x) disable iff (rst)
    (master_ph == 1'b0 && !rd_req_n) |-> ##3 rd_valid);

  assert_read_deselect_R1: assert property (@(posedge clk2x) disable iff (rst)
    (master_ph == 1'b0 && rd_req_n) |-> ##3 !rd_valid);

  assert_phase_toggle_R9: assert property (@(posedge clk2x) disable iff (rst)
    1'b1 |=> master_ph != $past(master_ph));

  assert_reset_idle_R8: assert property (@(posedge clk2x)
    rst |=> (!rd_valid && master_ph == 1'b0));
endmodule

bind burst2_sram burst2_sram_chk #(.DW(DW)) u_chk (
  .clk2x(clk2x), .rst(rst), .rd_req_n(rd_req_n),
  .rd_valid(rd_valid), .rd_data(rd_data), .master_ph(master_ph)
);

// File: tb/tb_burst2_sram.sv
`timescale 1ns/1ps
module tb_burst2_sram;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int PAIRS = 1 << AW;

  logic          clk2x = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req_n = 1'b1, wr_req_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid, master_ph;
  logic [DW-1:0] rd_data;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  // bench pair model
  logic [DW-1:0] refm [2*PAIRS];
  bit            mr_pend = 1'b0, mw_pend = 1'b0;
  int            mr_a = 0;
  logic [DW-1:0] mw_b0 = '0;

  burst2_sram #(.AW(AW), .DW(DW)) dut (
    .clk2x(clk2x), .rst(rst), .rd_req_n(rd_req_n), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req_n(wr_req_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .master_ph(master_ph)
  );

  always #10 clk2x = ~clk2x;  // 50 MHz

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One master cycle; entered and left at a negedge before a master edge
  task automatic mcyc(input bit rn, input int ra, input bit wn, input int wa,
                      input logic [DW-1:0] wd);
    bit ev;
    logic [DW-1:0] e0, e1;
    check("R9 phase before master edge", int'(master_ph), 0);
    rd_req_n = rn; rd_addr = AW'(ra); wr_req_n = wn; wr_addr = AW'(wa); wr_data = wd;
    // model of the master edge: commit first, then serve the earlier read
    if (mw_pend) begin
      refm[2*wa] = mw_b0;
      refm[2*wa+1] = wd;
    end
    ev = mr_pend;
    e0 = refm[2*mr_a];
    e1 = refm[2*mr_a+1];
    mr_pend = !rn; mr_a = ra;
    mw_pend = !wn;
    if (!wn) mw_b0 = wd;
    @(posedge clk2x); @(negedge clk2x);
    check("R1/R3 beat0 valid", int'(rd_valid), int'(ev));
    check("R2/R7 beat0 even word", int'(rd_data), ev ? int'(e0) : 0);
    // R10: junk at the mid-cycle edge must be ignored
    rd_req_n = 1'b0; rd_addr = ~AW'(ra); wr_req_n = 1'b0;
    wr_addr = ~AW'(wa); wr_data = ~wd;
    @(posedge clk2x); @(negedge clk2x);
    check("R2/R3 beat1 valid", int'(rd_valid), int'(ev));
    check("R2/R7/R10 beat1 odd word", int'(rd_data), ev ? int'(e1) : 0);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; rd_req_n = 1'b0; wr_req_n = 1'b0;
    repeat (n) @(posedge clk2x);
    @(negedge clk2x);
    rst = 1'b0;
    mr_pend = 1'b0; mw_pend = 1'b0;
    check("R8 valid after reset", int'(rd_valid), 0);
    check("R8 data after reset", int'(rd_data), 0);
  endtask

  initial begin
    int wp;
    for (int i = 0; i < 2*PAIRS; i++) refm[i] = '0;
    @(negedge clk2x);
    do_reset(3);
    // R4: fill every pair, writes only
    for (int k = 0; k <= PAIRS; k++)
      mcyc(1'b1, 0, (k == PAIRS), (k > 0) ? k - 1 : 0, DW'(k*29 + 3));
    // R4/R2: read every pair back, R5: write deselect all along
    for (int k = 0; k <= PAIRS; k++)
      mcyc((k == PAIRS), k % PAIRS, 1'b1, 0, DW'(k));
    // R7: directed collision, read and write command on the same edge
    mcyc(1'b0, 2, 1'b0, 0, 8'h5A);
    mcyc(1'b1, 0, 1'b1, 2, 8'hC3);
    mcyc(1'b0, 2, 1'b1, 0, 8'h00);
    mcyc(1'b1, 0, 1'b1, 0, 8'h00);
    // R6/R7/R5/R1: mixed sweeps with different enable and address patterns
    wp = 0;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 24; k++) begin
        int nwp;
        nwp = (k*5 + r) % PAIRS;
        mcyc(((k + r) % 3 == 0), (r == 1) ? nwp : (k*(2*r+1) + r) % PAIRS,
             ((k + r) % 4 == 1), wp, DW'(r*37 + k*11 + 1));
        wp = nwp;
      end
    end
    mcyc(1'b1, 0, 1'b1, wp, 8'h77);
    // R8: reset cancels a pending read and a pending write; array survives
    mcyc(1'b0, 5, 1'b0, 0, 8'hEE);
    do_reset(2);
    mcyc(1'b1, 0, 1'b1, 3, 8'h11);  // no read beats, nothing committed
    mcyc(1'b0, 5, 1'b1, 0, 8'h22);
    mcyc(1'b0, 3, 1'b1, 0, 8'h33);
    mcyc(1'b1, 0, 1'b1, 0, 8'h44);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk2x);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule